// File: doc/BRIEF.md
# Interrupt Source Gating Unit

This block holds one bank of interrupt sources for a multiprocessor interrupt controller. Every source owns a configuration word (mask, priority, vector, plus read-only sense and activity flags) and a destination word that selects which processors may receive it. Both are written over a small register port that gives a register select, a source index and a data word. Each source keeps a pending flag, fed by its input line according to its sense (level or rising edge), and an activity flag that marks an interrupt already handed to a processor.

On every cycle each source decides, from its registered state, whether it may be delivered. A deliverable source drives a one-cycle raise strobe to every processor named in its destination word and sets its activity flag at the next clock edge, so that it is not delivered twice. A processor acknowledge on an edge source clears both flags; a level source loses both flags when its line drops. Because the decision is a function of the state, every input change, acknowledge and register write is followed by a fresh decision one clock later. Arbitration between sources is left to the per-processor logic that consumes the strobes.

Top module: `irq_src_gate`

## Requirements
- R1: After reset every source reads back configuration word 0x80000000 with the sense flag (bit 22) added for level sources, destination 0, pending and activity clear, and no raise strobe is driven.
- R2: A configuration write stores only bits 31 (mask), 19:16 (priority) and 7:0 (vector); a read returns those plus activity at bit 30 and the build-time sense at bit 22 (1 = level), with every other bit zero, so bit 20 and the distribution-mode bit 29 always read zero.
- R3: A destination write stores the low NUM_CPU data bits (bit c selects processor c) and ignores the rest.
- R4: A level source's pending flag equals its input as sampled at the last clock edge; sampling the input low clears its activity flag.
- R5: An edge source sets pending on a sampled 0-to-1 input transition and keeps it when the input falls, until acknowledged.
- R6: An acknowledge (ack_i with ack_idx_i) on an edge source clears its pending and activity flags, unless a new rising edge arrives in the same cycle, which leaves pending set; on a level source an acknowledge has no effect.
- R7: A source is delivered only when it is pending, unmasked, has nonzero priority, has activity clear and has a nonzero destination.
- R8: Delivery of source s drives raise_o bit c*NUM_SRC+s high for each processor c whose destination bit is set, in the cycle after the state that makes it deliverable is registered, and for one cycle only.
- R9: Delivery sets the activity flag at the next clock edge and blocks further delivery until the flag is cleared; no register write can change the flag.
- R10: A register write that makes a pending source deliverable (unmask, priority, destination) produces its raise strobe in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | NUM_SRC | Interrupt input lines, one per source |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 configuration word, 1 destination word |
| reg_idx_i | input | IDX_W | Source index of the write |
| reg_wdata_i | input | 32 | Write data |
| ack_i | input | 1 | Processor acknowledge strobe |
| ack_idx_i | input | IDX_W | Source index being acknowledged |
| rd_idx_i | input | IDX_W | Source index for readback |
| rd_cfg_o | output | 32 | Configuration word of the selected source |
| rd_dest_o | output | NUM_CPU | Destination word of the selected source |
| raise_o | output | NUM_CPU*NUM_SRC | Raise strobes, bit c*NUM_SRC+s for processor c, source s |

## Verification
On every cycle the assertions check the flag dynamics of each source: activity rises only after a delivery, a delivery strobe lasts one cycle, an acknowledged edge source loses both flags, an edge source holds pending until acknowledged, and a low level input empties a level source. What only the bench's scenarios can show is the mapping from data to state: the write masks, the readback layout with sense and activity, the five gating conditions, the per-processor fan-out of each strobe and the timing of re-evaluation after writes, all compared against a cycle model across sweeps of all 64 sources and a long pseudo-random run.

// File: rtl/igu_pkg.sv
package igu_pkg;

  localparam logic [31:0] CFG_WMASK = 32'h800F_00FF;
  localparam int MASK_BIT  = 31;
  localparam int ACT_BIT   = 30;
  localparam int SENSE_BIT = 22;
  localparam int PRIO_LSB  = 16;

  typedef struct packed {
    logic       masked;
    logic [3:0] prio;
    logic [7:0] vec;
  } src_cfg_t;

  localparam src_cfg_t CFG_RESET = '{masked: 1'b1, prio: 4'd0, vec: 8'd0};

  // Keep only the software-writable fields of a configuration write.
  function automatic src_cfg_t cfg_from_word(input logic [31:0] w);
    logic [31:0] k;
    src_cfg_t c;
    k = w & CFG_WMASK;
    c.masked = k[MASK_BIT];
    c.prio   = k[PRIO_LSB +: 4];
    c.vec    = k[7:0];
    return c;
  endfunction

  // Assemble the readback word from stored fields and read-only flags.
  function automatic logic [31:0] cfg_to_word(input src_cfg_t c, input logic act,
                                              input logic sense);
    logic [31:0] w;
    w = '0;
    w[MASK_BIT]         = c.masked;
    w[ACT_BIT]          = act;
    w[SENSE_BIT]        = sense;
    w[PRIO_LSB +: 4]    = c.prio;
    w[7:0]              = c.vec;
    return w;
  endfunction

  // The five delivery gates.
  function automatic logic may_deliver(input logic pend, input logic act,
                                       input src_cfg_t c, input logic has_dest);
    return pend && !act && !c.masked && (c.prio != 4'd0) && has_dest;
  endfunction

endpackage

// File: rtl/igu_src_slot.sv
module igu_src_slot
  import igu_pkg::*;
#(
  parameter int NUM_CPU = 2,
  parameter bit LEVEL   = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               irq_i,
  input  logic               cfg_we_i,
  input  logic               dst_we_i,
  input  logic [31:0]        wdata_i,
  input  logic               ack_i,
  output logic [31:0]        cfg_word_o,
  output logic [NUM_CPU-1:0] dest_o,
  output logic               fire_o
);

  src_cfg_t           cfg;
  logic [NUM_CPU-1:0] dest;
  logic               pend, act, irq_q;
  logic               pend_nx, act_nx;
  logic               rise;

  assign rise   = irq_i & ~irq_q;
  assign fire_o = may_deliver(pend, act, cfg, |dest);

  generate
    if (LEVEL) begin : g_level
      assign pend_nx = irq_i;
      assign act_nx  = irq_i & (act | fire_o);
    end else begin : g_edge
      assign pend_nx = rise | (pend & ~ack_i);
      assign act_nx  = ~ack_i & (act | fire_o);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg   <= CFG_RESET;
      dest  <= '0;
      pend  <= 1'b0;
      act   <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_i;
      pend  <= pend_nx;
      act   <= act_nx;
      if (cfg_we_i) cfg  <= cfg_from_word(wdata_i);
      if (dst_we_i) dest <= wdata_i[NUM_CPU-1:0];
    end
  end

  assign cfg_word_o = cfg_to_word(cfg, act, LEVEL);
  assign dest_o     = dest;

  AST_ACT_ONLY_BY_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act) |-> $past(fire_o)); // R9

  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_o && !(ack_i && rise)) |=> !fire_o); // R8

  generate
    if (LEVEL) begin : g_lvl_chk
      AST_LEVEL_LOW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_i |=> (!pend && !act)); // R4
    end else begin : g_edge_chk
      AST_EDGE_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !rise) |=> (!pend && !act)); // R6
      AST_EDGE_HOLDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !ack_i) |=> pend); // R5
    end
  endgenerate

endmodule

// File: rtl/igu_read_mux.sv
module igu_read_mux #(
  parameter int NUM_SRC = 64,
  parameter int NUM_CPU = 2,
  parameter int IDX_W   = $clog2(NUM_SRC)
) (
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [31:0]        cfg_words_i [NUM_SRC],
  input  logic [NUM_CPU-1:0] dests_i     [NUM_SRC],
  output logic [31:0]        cfg_o,
  output logic [NUM_CPU-1:0] dest_o
);

  always_comb begin
    cfg_o  = '0;
    dest_o = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (idx_i == IDX_W'(s)) begin
        cfg_o  = cfg_words_i[s];
        dest_o = dests_i[s];
      end
    end
  end

endmodule

// File: rtl/irq_src_gate.sv
module irq_src_gate #(
  parameter int          NUM_SRC   = 64,
  parameter int          NUM_CPU   = 2,
  parameter logic [63:0] LEVEL_SRC = 64'hFFFF_FFFF_0000_0000,
  parameter int          IDX_W     = $clog2(NUM_SRC)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_SRC-1:0]         irq_i,
  input  logic                       reg_we_i,
  input  logic                       reg_sel_i,
  input  logic [IDX_W-1:0]           reg_idx_i,
  input  logic [31:0]                reg_wdata_i,
  input  logic                       ack_i,
  input  logic [IDX_W-1:0]           ack_idx_i,
  input  logic [IDX_W-1:0]           rd_idx_i,
  output logic [31:0]                rd_cfg_o,
  output logic [NUM_CPU-1:0]         rd_dest_o,
  output logic [NUM_CPU*NUM_SRC-1:0] raise_o
);

  logic [NUM_SRC-1:0] fire;
  logic [NUM_SRC-1:0] cfg_we, dst_we, ack_hit;
  logic [31:0]        cfg_words [NUM_SRC];
  logic [NUM_CPU-1:0] dests     [NUM_SRC];

  generate
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      assign cfg_we[s]  = reg_we_i & ~reg_sel_i & (reg_idx_i == IDX_W'(s));
      assign dst_we[s]  = reg_we_i &  reg_sel_i & (reg_idx_i == IDX_W'(s));
      assign ack_hit[s] = ack_i & (ack_idx_i == IDX_W'(s));

      igu_src_slot #(
        .NUM_CPU (NUM_CPU),
        .LEVEL   (LEVEL_SRC[s])
      ) u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_i      (irq_i[s]),
        .cfg_we_i   (cfg_we[s]),
        .dst_we_i   (dst_we[s]),
        .wdata_i    (reg_wdata_i),
        .ack_i      (ack_hit[s]),
        .cfg_word_o (cfg_words[s]),
        .dest_o     (dests[s]),
        .fire_o     (fire[s])
      );

      for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        assign raise_o[c*NUM_SRC + s] = fire[s] & dests[s][c];
      end
    end
  endgenerate

  igu_read_mux #(
    .NUM_SRC (NUM_SRC),
    .NUM_CPU (NUM_CPU),
    .IDX_W   (IDX_W)
  ) u_rd (
    .idx_i       (rd_idx_i),
    .cfg_words_i (cfg_words),
    .dests_i     (dests),
    .cfg_o       (rd_cfg_o),
    .dest_o      (rd_dest_o)
  );

  AST_NO_RAISE_IN_RESET: assert property (@(posedge clk)
    !rst_n |-> (raise_o == '0)); // R1

endmodule

// File: tb/irq_src_gate_tb.sv
module irq_src_gate_tb;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NS = 64;
  localparam int NC = 2;
  localparam logic [63:0] LVL = 64'hFFFF_FFFF_0000_0000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] irq = '0;
  logic          we = 1'b0, sel = 1'b0;
  logic [5:0]    widx = '0;
  logic [31:0]   wdata = '0;
  logic          ack = 1'b0;
  logic [5:0]    aidx = '0, ridx = '0;
  logic [31:0]   rd_cfg;
  logic [NC-1:0] rd_dest;
  logic [NC*NS-1:0] raise;

  always #2 clk = ~clk;

  irq_src_gate u_dut (
    .clk(clk), .rst_n(rst_n), .irq_i(irq), .reg_we_i(we), .reg_sel_i(sel),
    .reg_idx_i(widx), .reg_wdata_i(wdata), .ack_i(ack), .ack_idx_i(aidx),
    .rd_idx_i(ridx), .rd_cfg_o(rd_cfg), .rd_dest_o(rd_dest), .raise_o(raise)
  );

  // Cycle model built from the requirements.
  logic          m_mask [NS];
  logic [3:0]    m_prio [NS];
  logic [7:0]    m_vec  [NS];
  logic [NC-1:0] m_dest [NS];
  logic [NS-1:0] m_pend, m_act, m_prev;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] lf = 32'h1234_5678;

  function automatic logic [31:0] nxt(input logic [31:0] x);
    x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
    return x;
  endfunction

  function automatic logic m_fire(input int s);
    return m_pend[s] && !m_act[s] && !m_mask[s] && m_prio[s] != 0 && m_dest[s] != 0;
  endfunction

  function automatic logic [31:0] exp_word(input int s);
    return ({31'd0, m_mask[s]} << 31) | ({31'd0, m_act[s]} << 30) |
           ({31'd0, LVL[s]} << 22) | ({28'd0, m_prio[s]} << 16) | {24'd0, m_vec[s]};
  endfunction

  function automatic logic [NC*NS-1:0] exp_raise();
    logic [NC*NS-1:0] r = '0;
    for (int s = 0; s < NS; s++)
      for (int c = 0; c < NC; c++)
        r[c*NS+s] = m_fire(s) && m_dest[s][c];
    return r;
  endfunction

  task automatic model_reset();
    for (int s = 0; s < NS; s++) begin
      m_mask[s] = 1'b1; m_prio[s] = '0; m_vec[s] = '0; m_dest[s] = '0;
    end
    m_pend = '0; m_act = '0; m_prev = '0;
  endtask

  task automatic model_step();
    logic [NS-1:0] f;
    for (int s = 0; s < NS; s++) f[s] = m_fire(s);
    for (int s = 0; s < NS; s++) begin
      logic a, r;
      a = ack && (aidx == 6'(s));
      r = irq[s] && !m_prev[s];
      if (LVL[s]) begin
        m_pend[s] = irq[s];
        m_act[s]  = irq[s] && (m_act[s] || f[s]);
      end else begin
        m_pend[s] = r || (m_pend[s] && !a);
        m_act[s]  = !a && (m_act[s] || f[s]);
      end
    end
    m_prev = irq;
    if (we && !sel) begin
      m_mask[widx] = wdata[31]; m_prio[widx] = wdata[19:16]; m_vec[widx] = wdata[7:0];
    end
    if (we && sel) m_dest[widx] = wdata[NC-1:0];
  endtask

  task automatic check(input string tag);
    logic [NC*NS-1:0] er;
    er = exp_raise();
    checks++;
    if (raise !== er) begin
      errors++;
      $display("FAIL %s raise: actual=%h expected=%h", tag, raise, er);
    end
    checks++;
    if (rd_cfg !== exp_word(int'(ridx))) begin
      errors++;
      $display("FAIL %s cfg[%0d]: actual=%h expected=%h", tag, ridx, rd_cfg, exp_word(int'(ridx)));
    end
    checks++;
    if (rd_dest !== m_dest[ridx]) begin
      errors++;
      $display("FAIL %s dest[%0d]: actual=%h expected=%h", tag, ridx, rd_dest, m_dest[ridx]);
    end
  endtask

  // Inputs are already set at a falling edge; apply one clock and compare.
  task automatic step(input string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    check(tag);
    we = 1'b0; ack = 1'b0;
  endtask

  task automatic wr(input logic s_dst, input int s, input logic [31:0] d, input string tag);
    we = 1'b1; sel = s_dst; widx = 6'(s); wdata = d; ridx = 6'(s);
    step(tag);
  endtask

  task automatic set_irq(input int s, input logic v, input string tag);
    irq[s] = v; ridx = 6'(s);
    step(tag);
  endtask

  task automatic do_ack(input int s, input string tag);
    ack = 1'b1; aidx = 6'(s); ridx = 6'(s);
    step(tag);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state of every source
    for (int s = 0; s < NS; s++) begin ridx = 6'(s); step("R1"); end
    // R2: write masks and readback layout, full sweep
    for (int s = 0; s < NS; s++) wr(1'b0, s, 32'hFFFF_FFFF, "R2");
    wr(1'b0, 5, 32'h7FF0_FF00, "R2");
    // R3: destination keeps low bits only
    for (int s = 0; s < NS; s++) wr(1'b1, s, 32'hFFFF_FFFC | 32'(s % 4), "R3");
    // R5/R8: edge source 3 (dest 3), unmasked priority 5
    wr(1'b0, 3, 32'h0005_0021, "R8");
    set_irq(3, 1'b1, "R5");
    set_irq(3, 1'b0, "R5");
    set_irq(3, 1'b1, "R9");
    wr(1'b0, 3, 32'h400A_0021, "R9");
    do_ack(3, "R6");
    step("R6");
    set_irq(3, 1'b0, "R5");
    set_irq(3, 1'b1, "R8");
    // R6: ack together with a new rising edge
    set_irq(3, 1'b0, "R6");
    irq[3] = 1'b1; do_ack(3, "R6");
    step("R6");
    do_ack(3, "R6");
    // R4: level source 40 to CPU 1
    wr(1'b1, 40, 32'h2, "R4");
    wr(1'b0, 40, 32'h0001_0010, "R4");
    set_irq(40, 1'b1, "R4");
    step("R4");
    do_ack(40, "R6");
    set_irq(40, 1'b0, "R4");
    set_irq(40, 1'b1, "R4");
    // R7/R10: gating by mask, priority and destination
    wr(1'b0, 10, 32'h8003_0001, "R7");
    set_irq(10, 1'b1, "R7");
    wr(1'b0, 10, 32'h0003_0001, "R10");
    wr(1'b0, 11, 32'h0000_0002, "R7");
    set_irq(11, 1'b1, "R7");
    wr(1'b0, 11, 32'h000F_0002, "R10");
    wr(1'b1, 12, 32'h0, "R7");
    wr(1'b0, 12, 32'h0002_0003, "R7");
    set_irq(12, 1'b1, "R7");
    wr(1'b1, 12, 32'h1, "R10");
    // Pseudo-random run against the model (R4..R10)
    for (int i = 0; i < 3000; i++) begin
      lf = nxt(lf);
      if (lf[2:0] == 0) irq[lf[8:3]] = ~irq[lf[8:3]];
      if (lf[10:9] == 0) irq[lf[16:11]] = ~irq[lf[16:11]];
      if (lf[19:17] == 0) begin
        we = 1'b1; sel = lf[20]; widx = lf[26:21];
        wdata = nxt(lf);
        if (lf[28:27] != 0) wdata[31] = 1'b0;
      end
      if (lf[29]) begin ack = 1'b1; aidx = nxt(~lf)[5:0]; end
      ridx = lf[31] ? widx : nxt(lf ^ 32'h55)[5:0];
      step("R7/R8 random");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule